// File: doc/BRIEF.md
# Ring ORAM Eviction Scheduler

This block paces the background work of a tree-structured oblivious memory whose buckets hold a shuffled mix of real blocks and a budget of spare dummy slots. For each accepted access it first issues a path-read command for the requested leaf. It then walks that path from the root down, checking how many times each bucket has been read since it was last rewritten, and issues a reshuffle command for every bucket that has used up its dummy budget. Finally, once in every `EVICT_RATE` accesses, it issues a path-eviction command. Successive evictions visit the leaves in bit-reversed counter order, so that the write-back load spreads evenly over the tree.

The block holds only counters: one small read counter per bucket, an access pacer and an eviction counter. Bucket contents, slot permutations and encryption belong to the datapath that consumes the commands. A bucket counter returns to zero whenever its bucket is rewritten, either by a reshuffle or by an eviction whose path passes through it.

Top module: `ring_evict_sched`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` is 0 and every bucket read counter, the access pacer and the eviction counter are zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the block presents `cmd_valid`=1, `cmd_kind`=1 (path read), `cmd_leaf` equal to the accepted leaf and `cmd_level`=0.
- R3: Accepting a request adds one to the read counter of every bucket on the requested path, from the root down to the leaf.
- R4: In the cycles from 2 to `LEVELS`+2 after acceptance, the block checks one level per cycle, root first. For a bucket whose counter has reached `DUMMY_SLOTS`, it presents `cmd_kind`=3 (reshuffle) with the accessed leaf and that level. In any other such cycle `cmd_valid` is 0.
- R5: A reshuffle command sets the read counter of its bucket to zero.
- R6: In cycle `LEVELS`+3 after acceptance, the block issues `cmd_kind`=2 (evict) with `cmd_level`=0 if and only if the number of accepted requests since reset is a multiple of `EVICT_RATE`. Otherwise `cmd_valid` is 0 in that cycle.
- R7: The k-th eviction (counting from k=0) targets the leaf whose bit i equals bit `LEVELS`-1-i of k mod 2^`LEVELS`. For 4 leaves the order is 0, 2, 1, 3.
- R8: An eviction sets the read counters of all buckets on its path to zero.
- R9: `req_ready` is 0 from the edge that accepts a request until the eviction cycle, in which it is 1 again. A `req_valid` that is raised while `req_ready` is 0 is ignored. Because `DUMMY_SLOTS` > `EVICT_RATE`, the root never gets a reshuffle command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_leaf | input | LEVELS | Leaf of the path to access |
| req_ready | output | 1 | Scheduler idle, request can be accepted |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_kind | output | 2 | 1 read path, 2 evict path, 3 reshuffle bucket |
| cmd_leaf | output | LEVELS | Leaf naming the path of the command |
| cmd_level | output | $clog2(LEVELS+1) | Bucket depth for a reshuffle, 0 otherwise |

## Verification
The bench runs a tree of four leaves with an eviction every three accesses and a budget of four dummies, and compares the commands against a small arithmetic model. One leaf hammered repeatedly drives the deep buckets off the eviction paths to exhaustion, so the reshuffle level and its counter clear become visible. A leaf sweep in ascending order and a strided leaf pattern mix evictions that do and do not cover the accessed path, which separates a clear on eviction from a clear on reshuffle. Requests pulsed while the block is busy show whether a busy-time request leaks into the counters or the command stream.

// File: rtl/ring_sched_pkg.sv
package ring_sched_pkg;
   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_READ    = 2'd1,
      CMD_EVICT   = 2'd2,
      CMD_RESHUF  = 2'd3
   } cmd_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_EVICT = 2'd2
   } sched_state_e;
endpackage

// File: rtl/evict_leaf_gen.sv
module evict_leaf_gen #(
   parameter int LEVELS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [LEVELS-1:0] leaf
);
   logic [LEVELS-1:0] ev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ev_q <= '0;
      else if (advance) ev_q <= ev_q + 1'b1;
   end

   // bit reversal gives the spread-out leaf order
   for (genvar i = 0; i < LEVELS; i++) begin : g_rev
      assign leaf[i] = ev_q[LEVELS-1-i];
   end
endmodule

// File: rtl/access_pacer.sv
module access_pacer #(
   parameter int RATE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   output logic due
);
   localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;

   logic [CW-1:0] cnt_q;
   logic          due_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         due_q <= 1'b0;
      end else begin
         if (take) due_q <= 1'b0;
         if (tick) begin
            if (cnt_q == CW'(RATE-1)) begin
               cnt_q <= '0;
               due_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign due = due_q;
endmodule

// File: rtl/bucket_read_tracker.sv
module bucket_read_tracker #(
   parameter int LEVELS = 3,
   parameter int BUDGET = 4,
   localparam int LW = $clog2(LEVELS+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en,
   input  logic [LEVELS-1:0] inc_leaf,
   input  logic              clr_path_en,
   input  logic [LEVELS-1:0] clr_path_leaf,
   input  logic              clr_one_en,
   input  logic [LW-1:0]     clr_one_level,
   input  logic [LEVELS-1:0] clr_one_leaf,
   input  logic [LW-1:0]     qry_level,
   input  logic [LEVELS-1:0] qry_leaf,
   output logic              qry_exhausted
);
   localparam int NB = (2**(LEVELS+1)) - 1;
   localparam int CW = $clog2(BUDGET+1);

   logic [CW-1:0] cnt_w [NB];

   for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
      for (genvar pos = 0; pos < 2**lv; pos++) begin : g_pos
         localparam int ID = (2**lv) - 1 + pos;
         logic [CW-1:0] c_q;
         logic on_inc, on_path, on_one;

         assign on_inc  = (inc_leaf      >> (LEVELS-lv)) == LEVELS'(pos);
         assign on_path = (clr_path_leaf >> (LEVELS-lv)) == LEVELS'(pos);
         assign on_one  = (clr_one_level == LW'(lv)) &&
                          ((clr_one_leaf >> (LEVELS-lv)) == LEVELS'(pos));

         always_ff @(posedge clk) begin
            if (!rst_n)                            c_q <= '0;
            else if (clr_path_en && on_path)       c_q <= '0;
            else if (clr_one_en && on_one)         c_q <= '0;
            else if (inc_en && on_inc && c_q != CW'(BUDGET)) c_q <= c_q + 1'b1;
         end

         assign cnt_w[ID] = c_q;
      end
   end

   logic [CW-1:0] q_cnt;
   always_comb begin
      int qid;
      qid = (1 << qry_level) - 1 + int'(qry_leaf >> (LEVELS - int'(qry_level)));
      if (qid < 0 || qid >= NB) qid = 0;
      q_cnt = cnt_w[qid];
   end

   assign qry_exhausted = (q_cnt >= CW'(BUDGET));
endmodule

// File: rtl/ring_evict_sched.sv
module ring_evict_sched
   import ring_sched_pkg::*;
#(
   parameter int LEVELS      = 3,
   parameter int EVICT_RATE  = 3,
   parameter int DUMMY_SLOTS = 4,
   localparam int LW = $clog2(LEVELS+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LEVELS-1:0] req_leaf,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [LEVELS-1:0] cmd_leaf,
   output logic [LW-1:0]     cmd_level
);
   initial begin
      if (LEVELS < 1 || LEVELS > 10) $error("LEVELS out of range");
      if (EVICT_RATE < 1)            $error("EVICT_RATE must be at least 1");
      if (DUMMY_SLOTS <= EVICT_RATE) $error("DUMMY_SLOTS must exceed EVICT_RATE");
   end

   sched_state_e      st_q;
   logic [LW-1:0]     lvl_q;
   logic [LEVELS-1:0] leaf_q;
   logic              accept, exhausted, due, do_evict, do_reshuf;
   logic [LEVELS-1:0] ev_leaf;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign do_reshuf = (st_q == ST_SCAN) && exhausted;
   assign do_evict  = (st_q == ST_EVICT) && due;

   access_pacer #(.RATE(EVICT_RATE)) u_pacer (
      .clk(clk), .rst_n(rst_n), .tick(accept), .take(do_evict), .due(due)
   );

   evict_leaf_gen #(.LEVELS(LEVELS)) u_leafgen (
      .clk(clk), .rst_n(rst_n), .advance(do_evict), .leaf(ev_leaf)
   );

   bucket_read_tracker #(.LEVELS(LEVELS), .BUDGET(DUMMY_SLOTS)) u_tracker (
      .clk(clk), .rst_n(rst_n),
      .inc_en(accept), .inc_leaf(req_leaf),
      .clr_path_en(do_evict), .clr_path_leaf(ev_leaf),
      .clr_one_en(do_reshuf), .clr_one_level(lvl_q), .clr_one_leaf(leaf_q),
      .qry_level(lvl_q), .qry_leaf(leaf_q), .qry_exhausted(exhausted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         lvl_q     <= '0;
         leaf_q    <= '0;
         cmd_valid <= 1'b0;
         cmd_kind  <= CMD_NONE;
         cmd_leaf  <= '0;
         cmd_level <= '0;
      end else begin
         cmd_valid <= 1'b0;
         cmd_kind  <= CMD_NONE;
         cmd_leaf  <= '0;
         cmd_level <= '0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               leaf_q    <= req_leaf;
               lvl_q     <= '0;
               cmd_valid <= 1'b1;
               cmd_kind  <= CMD_READ;
               cmd_leaf  <= req_leaf;
               st_q      <= ST_SCAN;
            end
            ST_SCAN: begin
               if (exhausted) begin
                  cmd_valid <= 1'b1;
                  cmd_kind  <= CMD_RESHUF;
                  cmd_leaf  <= leaf_q;
                  cmd_level <= lvl_q;
               end
               if (lvl_q == LW'(LEVELS)) st_q <= ST_EVICT;
               else                      lvl_q <= lvl_q + 1'b1;
            end
            ST_EVICT: begin
               if (due) begin
                  cmd_valid <= 1'b1;
                  cmd_kind  <= CMD_EVICT;
                  cmd_leaf  <= ev_leaf;
               end
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ring_evict_sched_chk.sv
module ring_evict_sched_chk #(
   parameter int LEVELS      = 3,
   parameter int EVICT_RATE  = 3,
   parameter int DUMMY_SLOTS = 4,
   localparam int LW = $clog2(LEVELS+1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [LEVELS-1:0] req_leaf,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic [1:0]        cmd_kind,
   input logic [LEVELS-1:0] cmd_leaf,
   input logic [LW-1:0]     cmd_level
);
   localparam int AW = $clog2(EVICT_RATE+1);

   logic [AW-1:0]     acc_q;
   logic [LEVELS-1:0] ev_q;
   logic              evict_seen;

   assign evict_seen = cmd_valid && (cmd_kind == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ev_q  <= '0;
      end else begin
         if (req_valid && req_ready)
            acc_q <= (acc_q == AW'(EVICT_RATE-1)) ? '0 : acc_q + 1'b1;
         if (evict_seen) ev_q <= ev_q + 1'b1;
      end
   end

   function automatic logic [LEVELS-1:0] rev(input logic [LEVELS-1:0] v);
      for (int i = 0; i < LEVELS; i++) rev[i] = v[LEVELS-1-i];
   endfunction

   AST_READ_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (cmd_valid && cmd_kind == 2'd1 && cmd_leaf == $past(req_leaf))); // R2
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R9
   AST_EVICT_PACING: assert property (@(posedge clk) disable iff (!rst_n)
      evict_seen |-> (acc_q == '0)); // R6
   AST_EVICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      evict_seen |-> (cmd_leaf == rev(ev_q) && cmd_level == '0)); // R7
   AST_NO_ROOT_RESHUF: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd3) |-> (cmd_level != '0)); // R9
   AST_VALID_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_kind != 2'd0)); // R4
endmodule

bind ring_evict_sched ring_evict_sched_chk #(
   .LEVELS(LEVELS), .EVICT_RATE(EVICT_RATE), .DUMMY_SLOTS(DUMMY_SLOTS)
) u_chk (.*);

// File: tb/ring_evict_sched_tb.sv
module ring_evict_sched_tb;
   localparam int L  = 2;
   localparam int A  = 3;
   localparam int Y  = 4;
   localparam int LW = $clog2(L+1);
   localparam int NB = (2**(L+1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [L-1:0] req_leaf = '0;
   logic req_ready, cmd_valid;
   logic [1:0] cmd_kind;
   logic [L-1:0] cmd_leaf;
   logic [LW-1:0] cmd_level;

   int errors = 0;
   int checks = 0;
   int m_cnt [NB];
   int m_acc = 0;
   int m_ev  = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ring_evict_sched #(.LEVELS(L), .EVICT_RATE(A), .DUMMY_SLOTS(Y)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_leaf(req_leaf),
      .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_leaf(cmd_leaf), .cmd_level(cmd_level)
   );

   function automatic int bid(int lv, int leaf);
      return (1 << lv) - 1 + (leaf >> (L - lv));
   endfunction

   function automatic int rev(int v);
      int r = 0;
      for (int i = 0; i < L; i++) if (v[i]) r |= 1 << (L-1-i);
      return r;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pack_cmd();
      return {cmd_valid, cmd_kind, 4'(cmd_leaf), 4'(cmd_level)};
   endfunction

   function automatic int mk(int v, int k, int lf, int lv);
      return (v << 10) | (k << 8) | (lf << 4) | lv;
   endfunction

   // called at a negedge with req_ready high
   task automatic access(int leaf, bit noise);
      req_valid = 1'b1;
      req_leaf  = L'(leaf);
      @(negedge clk);
      req_valid = 1'b0;
      for (int lv = 0; lv <= L; lv++) m_cnt[bid(lv, leaf)]++;   // R3 model
      m_acc++;
      check("R2 read cmd", pack_cmd(), mk(1, 1, leaf, 0));
      check("R9 busy", int'(req_ready), 0);
      for (int lv = 0; lv <= L; lv++) begin
         if (noise) begin
            req_valid = 1'b1;
            req_leaf  = L'(~leaf);
         end
         @(negedge clk);
         req_valid = 1'b0;
         if (m_cnt[bid(lv, leaf)] >= Y) begin
            check("R4 reshuffle cmd", pack_cmd(), mk(1, 3, leaf, lv));
            m_cnt[bid(lv, leaf)] = 0;                             // R5 model
         end else begin
            check("R4 quiet level", pack_cmd(), mk(0, 0, 0, 0));
         end
         check("R9 busy in scan", int'(req_ready), 0);
      end
      @(negedge clk);
      if (m_acc == A) begin
         check("R6 R7 evict cmd", pack_cmd(), mk(1, 2, rev(m_ev % (1 << L)), 0));
         for (int lv = 0; lv <= L; lv++) m_cnt[bid(lv, rev(m_ev % (1 << L)))] = 0; // R8 model
         m_ev++;
         m_acc = 0;
      end else begin
         check("R6 no evict", pack_cmd(), mk(0, 0, 0, 0));
      end
      check("R9 ready again", int'(req_ready), 1);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) m_cnt[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready", int'(req_ready), 1);
      check("R1 idle cmd", int'(cmd_valid), 0);
      // same leaf repeatedly: deep buckets exhaust
      for (int i = 0; i < 12; i++) access(3, 1'b0);
      // ascending sweep
      for (int i = 0; i < 16; i++) access(i % 4, 1'b0);
      // strided pattern with busy-time noise
      for (int i = 0; i < 24; i++) access((i * 3 + 1) % 4, i[0]);
      // leaf 1 hammered with noise
      for (int i = 0; i < 10; i++) access(1, 1'b1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule